// File: doc/BRIEF.md
# Streaming Pixel Histogram Accumulator

The block counts how often each 8-bit intensity value occurs in one video frame. Pixels arrive on a data bus qualified by a one-cycle strobe. The first pixel of a frame is also marked by a frame-start flag. The 256 counters live in a single-port RAM inside the block, and only the block's controller can reach it. Each accepted pixel triggers a read-modify-write of its bin: the bin is read, the controller waits one cycle for the synchronous RAM, and then writes the value plus one back.

Once the configured number of pixels (frame width times frame height) has been counted, the block raises `done`. While it is idle, an external reader can fetch any bin through the same RAM port; each request is answered one cycle later. The next frame-start strobe after `done` drops `done` and starts a 256-cycle sweep that zeroes every bin. The sweep ignores the frame that triggered it, so accumulation resumes with the first frame start after the sweep ends. The same sweep also runs right after reset.

Top module: `pix_hist_top`

## Requirements
- R1: After reset `done` and `rdValid` are 0, and a sweep writes zero to all 256 bins; once it ends, every bin reads back 0.
- R2: When idle (no frame in progress, no sweep), `rdReq` high with `rdAddr` gives `rdValid` high one cycle later, with `rdData` equal to the count in bin `rdAddr`.
- R3: When idle, a frame begins only in a cycle where `frameStart` and `vidStb` are both high; either one alone changes no bin.
- R4: Every pixel accepted in a frame adds exactly one to the bin indexed by its 8-bit value. Each update takes four cycles, so strobes must be at least four cycles apart.
- R5: After the FRAME_W*FRAME_H-th pixel has been written, `done` rises and stays high until the next frame-start strobe, and the bins hold the frame's counts.
- R6: During a frame, `frameStart` is not examined; a strobe with `frameStart` high is counted as an ordinary pixel.
- R7: A `rdReq` during a frame or a sweep is ignored: `rdValid` stays 0.
- R8: A frame-start strobe while `done` is high clears `done` in the next cycle and starts a zeroing sweep; that frame's pixels and any frame-start strobe during the sweep are not counted.
- R9: Each bin is wide enough to hold FRAME_W*FRAME_H, so a frame made of a single value reads back the full pixel count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| vidStb | input | 1 | One-cycle strobe qualifying `pixData` |
| frameStart | input | 1 | Marks the first pixel of a frame |
| pixData | input | PIX_W | Pixel intensity |
| rdReq | input | 1 | External bin read request |
| rdAddr | input | PIX_W | Bin to read |
| rdData | output | CNT_W | Bin count, valid with `rdValid` |
| rdValid | output | 1 | Read data valid |
| done | output | 1 | Frame histogram complete |

## Verification
The histogram is compared after three kinds of frame. In the first, every pixel has the same value, which fills a single bin to the full pixel count and confirms that the bin does not wrap. In the second, the pixels follow a pseudo-random sequence that starts at bin 0 and ends at bin 255, with strobes at the four-cycle minimum spacing; this shows that closely spaced updates are neither dropped nor merged. In the third, a frame start arrives after `done` and another arrives during the sweep; a full readout of zeros shows that both were ignored while the bins were cleared. Lone strobes, lone frame-start flags, read requests during a frame, and a frame-start flag in the middle of a frame each confirm that these inputs act only in the states where they should.

// File: rtl/pix_hist_pkg.sv
package pix_hist_pkg;
  typedef enum logic [2:0] {
    ST_START, ST_READ_PIX, ST_READ_BIN, ST_WAIT_RAM, ST_WRITE_BIN
  } histState_t;

  typedef enum logic [1:0] {ADDR_PIX, ADDR_EXT, ADDR_SWEEP} addrSel_t;

  typedef struct packed {
    logic     capture;   // latch pixData, advance counter
    logic     cntClr;    // first pixel of a frame: counter restarts at one
    logic     ramRe;
    logic     ramWe;
    logic     wrZero;    // write zero instead of incremented bin
    logic     sweepInc;
    addrSel_t addrSel;
  } histCtl_t;
endpackage

// File: rtl/pix_hist_ram.sv
module pix_hist_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 6
) (
  input  logic              clk,
  input  logic              re,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/pix_hist_dp.sv
module pix_hist_dp
  import pix_hist_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int CNT_W = 6,
  parameter int NPIX  = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  histCtl_t         ctl,
  input  logic [PIX_W-1:0] pixData,
  input  logic [PIX_W-1:0] rdAddr,
  input  logic [CNT_W-1:0] ramQ,
  output logic [PIX_W-1:0] ramAddr,
  output logic [CNT_W-1:0] ramWd,
  output logic             frameFull,
  output logic             sweepLast
);
  logic [PIX_W-1:0] pixReg;
  logic [CNT_W-1:0] pixCnt;
  logic [PIX_W-1:0] sweepAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixReg    <= '0;
      pixCnt    <= '0;
      sweepAddr <= '0;
    end else begin
      if (ctl.capture) begin
        pixReg <= pixData;
        pixCnt <= ctl.cntClr ? CNT_W'(1) : pixCnt + 1'b1;
      end
      if (ctl.sweepInc) sweepAddr <= sweepAddr + 1'b1;
    end
  end

  always_comb begin
    unique case (ctl.addrSel)
      ADDR_EXT:   ramAddr = rdAddr;
      ADDR_SWEEP: ramAddr = sweepAddr;
      default:    ramAddr = pixReg;
    endcase
  end

  assign ramWd     = ctl.wrZero ? '0 : ramQ + 1'b1;
  assign frameFull = (pixCnt == CNT_W'(NPIX));
  assign sweepLast = (sweepAddr == {PIX_W{1'b1}});

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.ramWe && !ctl.wrZero) |-> (ramQ != {CNT_W{1'b1}})); // R9
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.ramWe && !ctl.wrZero) |-> $past(ctl.ramRe, 2)); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pixCnt <= CNT_W'(NPIX)); // R5
endmodule

// File: rtl/pix_hist_ctrl.sv
module pix_hist_ctrl
  import pix_hist_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     vidStb,
  input  logic     frameStart,
  input  logic     rdReq,
  input  logic     frameFull,
  input  logic     sweepLast,
  output histCtl_t ctl,
  output logic     done,
  output logic     rdValid
);
  histState_t state, nextState;
  logic sweeping, idle, startEv;

  assign idle    = (state == ST_START) && !sweeping;
  assign startEv = idle && frameStart && vidStb;

  always_comb begin
    ctl       = '0;
    ctl.addrSel = ADDR_PIX;
    nextState = state;
    unique case (state)
      ST_START: begin
        if (sweeping) begin
          ctl.ramWe    = 1'b1;
          ctl.wrZero   = 1'b1;
          ctl.sweepInc = 1'b1;
          ctl.addrSel  = ADDR_SWEEP;
        end else if (startEv && !done) begin
          ctl.capture = 1'b1;
          ctl.cntClr  = 1'b1;
          nextState   = ST_READ_BIN;
        end else if (!startEv && rdReq) begin
          ctl.ramRe   = 1'b1;
          ctl.addrSel = ADDR_EXT;
        end
      end
      ST_READ_PIX: if (vidStb) begin
        ctl.capture = 1'b1;
        nextState   = ST_READ_BIN;
      end
      ST_READ_BIN: begin
        ctl.ramRe = 1'b1;
        nextState = ST_WAIT_RAM;
      end
      ST_WAIT_RAM: nextState = ST_WRITE_BIN;
      ST_WRITE_BIN: begin
        ctl.ramWe = 1'b1;
        nextState = frameFull ? ST_START : ST_READ_PIX;
      end
      default: nextState = ST_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_START;
      sweeping <= 1'b1;
      done     <= 1'b0;
      rdValid  <= 1'b0;
    end else begin
      state   <= nextState;
      rdValid <= ctl.ramRe && (state == ST_START);
      if (startEv && done) begin
        done     <= 1'b0;
        sweeping <= 1'b1;
      end else if (state == ST_WRITE_BIN && frameFull) begin
        done <= 1'b1;
      end
      if (sweeping && sweepLast) sweeping <= 1'b0;
    end
  end

  AST_RDVALID_REQ: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdReq)); // R2
  AST_RDVALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(state == ST_START && !sweeping)); // R7
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (done && !(frameStart && vidStb)) |=> done); // R5
endmodule

// File: rtl/pix_hist_top.sv
module pix_hist_top #(
  parameter int PIX_W   = 8,
  parameter int FRAME_W = 8,
  parameter int FRAME_H = 4,
  localparam int NPIX   = FRAME_W * FRAME_H,
  localparam int CNT_W  = $clog2(NPIX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             vidStb,
  input  logic             frameStart,
  input  logic [PIX_W-1:0] pixData,
  input  logic             rdReq,
  input  logic [PIX_W-1:0] rdAddr,
  output logic [CNT_W-1:0] rdData,
  output logic             rdValid,
  output logic             done
);
  import pix_hist_pkg::*;

  histCtl_t         ctl;
  logic             frameFull, sweepLast;
  logic [PIX_W-1:0] ramAddr;
  logic [CNT_W-1:0] ramWd, ramQ;

  pix_hist_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .vidStb(vidStb), .frameStart(frameStart),
    .rdReq(rdReq), .frameFull(frameFull), .sweepLast(sweepLast),
    .ctl(ctl), .done(done), .rdValid(rdValid)
  );

  pix_hist_dp #(.PIX_W(PIX_W), .CNT_W(CNT_W), .NPIX(NPIX)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pixData(pixData), .rdAddr(rdAddr),
    .ramQ(ramQ), .ramAddr(ramAddr), .ramWd(ramWd),
    .frameFull(frameFull), .sweepLast(sweepLast)
  );

  pix_hist_ram #(.ADDR_W(PIX_W), .DATA_W(CNT_W)) ram_i (
    .clk(clk), .re(ctl.ramRe), .we(ctl.ramWe), .addr(ramAddr),
    .wd(ramWd), .q(ramQ)
  );

  assign rdData = ramQ;
endmodule

// File: tb/pix_hist_top_tb_top.sv
module pix_hist_top_tb_top;
  localparam int NPIX = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       vidStb = 1'b0;
  logic       frameStart = 1'b0;
  logic [7:0] pixData = '0;
  logic       rdReq = 1'b0;
  logic [7:0] rdAddr = '0;
  logic [5:0] rdData;
  logic       rdValid;
  logic       done;

  int errors = 0;
  int checks = 0;
  int refHist [256];
  int expQ [$];
  string expTag [$];
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pix_hist_top dut_i (
    .clk(clk), .rstN(rstN), .vidStb(vidStb), .frameStart(frameStart),
    .pixData(pixData), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdData(rdData), .rdValid(rdValid), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: compares each read response against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R7 unexpected rdValid", 1, 0);
      end else begin
        int e;
        string t;
        e = expQ.pop_front();
        t = expTag.pop_front();
        chk(int'(rdData) == e, t, int'(rdData), e);
      end
    end
  end

  task automatic readBin(input int a, input string tag);
    rdReq  = 1'b1;
    rdAddr = 8'(a);
    expQ.push_back(refHist[a]);
    expTag.push_back(tag);
    @(negedge clk);
    rdReq = 1'b0;
  endtask

  task automatic readAll(input string tag);
    for (int i = 0; i < 256; i++) readBin(i, tag);
    @(negedge clk);
    @(negedge clk);
    chk(expQ.size() == 0, "R2 all reads answered", expQ.size(), 0);
  endtask

  task automatic sendPix(input int v, input bit fs, input bit counts);
    vidStb = 1'b1; frameStart = fs; pixData = 8'(v);
    if (counts) refHist[v]++;
    @(negedge clk);
    vidStb = 1'b0; frameStart = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic clearRef();
    for (int i = 0; i < 256; i++) refHist[i] = 0;
  endtask

  task automatic waitDone(input string tag);
    for (int i = 0; i < 12 && !done; i++) @(negedge clk);
    chk(done == 1'b1, tag, done, 1);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish();
  end

  initial begin
    logic [7:0] lfsr;
    clearRef();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R1 done after reset", done, 0);
    chk(rdValid == 1'b0, "R1 rdValid after reset", rdValid, 0);
    repeat (270) @(negedge clk);
    readAll("R1 swept bin");

    // R3: lone strobe and lone frameStart do nothing
    sendPix(3, 1'b0, 1'b0);
    frameStart = 1'b1; pixData = 8'd4;
    @(negedge clk);
    frameStart = 1'b0;
    repeat (3) @(negedge clk);
    readBin(3, "R3 lone strobe");
    readBin(4, "R3 lone frameStart");
    @(negedge clk);
    chk(done == 1'b0, "R3 no frame started", done, 0);

    // Frame A: single value fills one bin (R9), frameStart mid-frame (R6)
    for (int i = 0; i < NPIX; i++) begin
      if (i == 12) rdReq = 1'b1;  // R7: request during frame
      sendPix(200, (i == 0) || (i == 10), 1'b1);
      rdReq = 1'b0;
      if (i == 5) chk(done == 1'b0, "R5 done low mid-frame", done, 0);
    end
    waitDone("R5 done after frame A");
    readBin(200, "R9 full count bin");
    readBin(199, "R4 neighbour bin low");
    readBin(201, "R4 neighbour bin high");
    readAll("R6 frame A readout");
    chk(done == 1'b1, "R5 done held through readout", done, 1);

    // R8: frame start after done triggers sweep, not counted
    vidStb = 1'b1; frameStart = 1'b1; pixData = 8'd5;
    @(negedge clk);
    vidStb = 1'b0; frameStart = 1'b0;
    chk(done == 1'b0, "R8 done cleared", done, 1'b0);
    clearRef();
    repeat (20) @(negedge clk);
    rdReq = 1'b1; rdAddr = 8'd7;  // R7: request during sweep
    @(negedge clk);
    rdReq = 1'b0;
    sendPix(9, 1'b1, 1'b0);
    repeat (280) @(negedge clk);
    chk(done == 1'b0, "R8 no frame during sweep", done, 0);
    readAll("R8 cleared bin");

    // Frame B: pseudo-random values at minimum spacing (R4)
    lfsr = 8'h5a;
    for (int i = 0; i < NPIX; i++) begin
      int v;
      if (i == 0) v = 0;
      else if (i == NPIX - 1) v = 255;
      else begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        v = (i % 7 == 0) ? 17 : int'(lfsr);
      end
      sendPix(v, i == 0, 1'b1);
    end
    waitDone("R5 done after frame B");
    readBin(0, "R4 bin 0");
    readBin(255, "R4 bin 255");
    readBin(17, "R4 repeated bin");
    readAll("R4 frame B readout");
    finish();
  end
endmodule